// File: doc/BRIEF.md
# Parking Bus Arbiter With Programmable External Priority

This block decides who drives a shared external bus: the group of on-chip masters, or a single external master. The handshake pins use active-low levels: the external master raises a request on `ext_br_n`, receives a grant on `ext_bg_n`, and everyone watches the shared busy line `bus_bb_n`. The block drives its own contribution to that line on `own_bb_n`. A strap input, sampled only while reset is held, selects one of two modes. In the first, this block is the arbiter. In the second, arbitration is handed to an outside arbiter through `arb_br_n`/`arb_bg_n`.

When this block is the arbiter, the on-chip side is parked on the bus after reset. A parked on-chip master that wants the bus while the busy line is free asserts busy in the next cycle. It does not request and does not wait for a grant. The external master is granted in two cases: when the on-chip side has no demand, or when the programmed external priority is strictly above the priority of the on-chip master now requesting or holding the bus. A transfer in progress is never cut short. A grant is issued only in the cycle the on-chip side lets go of busy. The external master takes ownership by pulling the busy line low once it holds the grant. The grant is then withdrawn and parking returns to the on-chip side when the line goes free again.

Top module: `park_bus_arbiter`

## Requirements
- R1: The mode strap `cfg_park_en` is sampled on every clock while `rst_n` is low. The value held at the last reset cycle decides the mode until the next reset, and later changes of the strap have no effect.
- R2: In internal-arbiter mode (strap 1) the block leaves reset parked. `onc_parked`=1, `ext_bg_n`=1, `own_bb_n`=1, `onc_grant`=0 and `arb_br_n`=1.
- R3: While parked, if `onc_req`=1 and `bus_bb_n`=1 at a clock edge and the external side does not win, then after that edge `own_bb_n`=0 and `onc_grant`=1. Neither `arb_br_n` nor `ext_bg_n` is asserted on the way.
- R4: While parked with `onc_req`=0, a low `ext_br_n` at a clock edge gives `ext_bg_n`=0 after that edge.
- R5: The external side wins against a requesting on-chip master only if the 3-bit external priority is strictly greater than `onc_prio` (unsigned, 7 highest). With equal or lower external priority, the on-chip master takes or keeps the bus.
- R6: While the block drives busy and `onc_xfer_busy`=1, busy stays driven. Ownership is released only at an edge where `onc_xfer_busy`=0 and either `onc_req`=0 or the external side wins. A grant then appears in the same cycle that `own_bb_n` returns high.
- R7: With `ext_bg_n`=0, the grant is withdrawn after the first edge where `bus_bb_n`=0 (external ownership) or where `ext_br_n`=1 (request withdrawn). During external ownership `own_bb_n` stays 1 even if `onc_req`=1, and parking returns after the edge where `bus_bb_n` is back at 1.
- R8: The external priority field resets to 4 and is replaced by `prio_wdata` at any edge with `prio_we`=1. The new value applies from the next edge.
- R9: In external-arbiter mode (strap 0) the block is never parked and never asserts `ext_bg_n`. An on-chip request drives `arb_br_n`=0 until an edge that sees `arb_bg_n`=0 and `bus_bb_n`=1, after which `onc_grant`=1 and `own_bb_n`=0. Release follows R6 with `onc_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_park_en | input | 1 | Mode strap: 1 internal arbiter with parking, 0 outside arbiter |
| prio_we | input | 1 | Write strobe for the external priority field |
| prio_wdata | input | 3 | New external priority |
| onc_req | input | 1 | On-chip side wants the bus |
| onc_prio | input | 3 | Priority of the current on-chip master |
| onc_xfer_busy | input | 1 | On-chip transfer in progress, must not be broken |
| ext_br_n | input | 1 | External master bus request, active low |
| bus_bb_n | input | 1 | Sampled shared bus-busy line, active low |
| arb_bg_n | input | 1 | Grant from outside arbiter (strap 0 mode), active low |
| ext_bg_n | output | 1 | Grant to external master, active low |
| own_bb_n | output | 1 | On-chip drive of the busy line, active low |
| onc_grant | output | 1 | On-chip side owns the bus |
| onc_parked | output | 1 | On-chip side parked, bus idle |
| arb_br_n | output | 1 | Request to outside arbiter (strap 0 mode), active low |

## Verification
The bench goes after the priority tie. A design that compares with greater-or-equal would hand the bus away at equal priority, and the bench shows this as an early `ext_bg_n` low. It also tests a higher-priority request that arrives mid-transfer: a design that preempts would drop `own_bb_n` while `onc_xfer_busy` is high. Other cases are a grant held after the external master has already pulled busy low, or after it has withdrawn its request. Both leave `ext_bg_n` stuck low. The last case changes the strap after reset: a design that follows the live strap would suddenly report parking or issue an external grant in the outside-arbiter mode.

// File: rtl/park_arb_pkg.sv
package park_arb_pkg;
  localparam int PRIO_W = 3;

  typedef enum logic [2:0] {
    ST_PARK    = 3'd0,  // internal mode, on-chip parked, bus idle
    ST_ONC_TEN = 3'd1,  // on-chip side drives busy
    ST_EXT_GNT = 3'd2,  // grant out, waiting for external busy
    ST_EXT_TEN = 3'd3,  // external master owns the line
    ST_NOPARK  = 3'd4,  // outside-arbiter mode, idle
    ST_ONC_WAIT= 3'd5   // outside-arbiter mode, request pending
  } own_state_e;
endpackage

// File: rtl/park_cfg_regs.sv
module park_cfg_regs #(
  parameter int PRIO_W = park_arb_pkg::PRIO_W,
  parameter logic [PRIO_W-1:0] PRIO_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pin,
  input  logic              prio_we,
  input  logic [PRIO_W-1:0] prio_wdata,
  output logic              int_mode,
  output logic [PRIO_W-1:0] ext_prio
);
  logic              mode_q;
  logic [PRIO_W-1:0] prio_q;

  // strap captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_pin;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       prio_q <= PRIO_RST;
    else if (prio_we) prio_q <= prio_wdata;
  end

  assign int_mode = mode_q;
  assign ext_prio = prio_q;

  // R1: mode frozen outside reset
  assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q));

  // R8: write lands on the next edge
  assert_prio_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prio_we |=> (prio_q == $past(prio_wdata)));
endmodule

// File: rtl/park_prio_cmp.sv
module park_prio_cmp #(
  parameter int PRIO_W = park_arb_pkg::PRIO_W
) (
  input  logic              ext_req,
  input  logic              onc_req,
  input  logic [PRIO_W-1:0] ext_prio,
  input  logic [PRIO_W-1:0] onc_prio,
  output logic              ext_wins
);
  logic strictly_above;

  assign strictly_above = (ext_prio > onc_prio);

  // ties stay with the on-chip side
  always_comb begin
    ext_wins = 1'b0;
    if (ext_req) ext_wins = !onc_req || strictly_above;
  end
endmodule

// File: rtl/park_owner_fsm.sv
module park_owner_fsm
  import park_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rst_park,
  input  logic int_mode,
  input  logic onc_req,
  input  logic onc_xfer_busy,
  input  logic ext_br_n,
  input  logic ext_wins,
  input  logic bus_bb_n,
  input  logic arb_bg_n,
  output logic ext_bg_n,
  output logic own_bb_n,
  output logic onc_grant,
  output logic onc_parked,
  output logic arb_br_n
);
  own_state_e state_q, state_d;
  own_state_e idle_st;
  logic       release_ok;

  assign idle_st    = int_mode ? ST_PARK : ST_NOPARK;
  assign release_ok = !onc_xfer_busy && (!onc_req || ext_wins);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PARK: begin
        if (ext_wins)                 state_d = ST_EXT_GNT;
        else if (onc_req && bus_bb_n) state_d = ST_ONC_TEN;
      end
      ST_ONC_TEN: begin
        if (release_ok) state_d = ext_wins ? ST_EXT_GNT : idle_st;
      end
      ST_EXT_GNT: begin
        if (ext_br_n)       state_d = ST_PARK;
        else if (!bus_bb_n) state_d = ST_EXT_TEN;
      end
      ST_EXT_TEN: begin
        if (bus_bb_n) state_d = ST_PARK;
      end
      ST_NOPARK: begin
        if (onc_req) state_d = ST_ONC_WAIT;
      end
      ST_ONC_WAIT: begin
        if (!onc_req)                    state_d = ST_NOPARK;
        else if (!arb_bg_n && bus_bb_n)  state_d = ST_ONC_TEN;
      end
      default: state_d = idle_st;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= rst_park ? ST_PARK : ST_NOPARK;
    else        state_q <= state_d;
  end

  assign ext_bg_n   = (state_q != ST_EXT_GNT);
  assign own_bb_n   = (state_q != ST_ONC_TEN);
  assign onc_grant  = (state_q == ST_ONC_TEN);
  assign onc_parked = (state_q == ST_PARK);
  assign arb_br_n   = (state_q != ST_ONC_WAIT);

  // R3: parked take-over goes straight to busy, no grant cycle
  assert_park_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (onc_parked && onc_req && bus_bb_n && !ext_wins) |=> (!own_bb_n && ext_bg_n && arb_br_n));

  // R5: a winning external request is granted from parking
  assert_ext_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (onc_parked && ext_wins) |=> !ext_bg_n);

  // R6: no preemption of a running transfer
  assert_no_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!own_bb_n && onc_xfer_busy) |=> !own_bb_n);

  // R7: grant withdrawn once the external master holds the line
  assert_grant_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_bg_n && !bus_bb_n) |=> ext_bg_n);

  // R9: outside-arbiter mode never grants the external master
  assert_no_grant_ext_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !int_mode |-> (ext_bg_n && !onc_parked));
endmodule

// File: rtl/park_bus_arbiter.sv
module park_bus_arbiter #(
  parameter int PRIO_W = park_arb_pkg::PRIO_W,
  parameter logic [PRIO_W-1:0] PRIO_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_park_en,
  input  logic              prio_we,
  input  logic [PRIO_W-1:0] prio_wdata,
  input  logic              onc_req,
  input  logic [PRIO_W-1:0] onc_prio,
  input  logic              onc_xfer_busy,
  input  logic              ext_br_n,
  input  logic              bus_bb_n,
  input  logic              arb_bg_n,
  output logic              ext_bg_n,
  output logic              own_bb_n,
  output logic              onc_grant,
  output logic              onc_parked,
  output logic              arb_br_n
);
  logic              int_mode;
  logic [PRIO_W-1:0] ext_prio;
  logic              ext_req;
  logic              ext_wins;

  park_cfg_regs #(.PRIO_W(PRIO_W), .PRIO_RST(PRIO_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .mode_pin(cfg_park_en),
    .prio_we(prio_we), .prio_wdata(prio_wdata),
    .int_mode(int_mode), .ext_prio(ext_prio)
  );

  // external requests count only when this block arbitrates
  assign ext_req = int_mode && !ext_br_n;

  park_prio_cmp #(.PRIO_W(PRIO_W)) u_cmp (
    .ext_req(ext_req), .onc_req(onc_req),
    .ext_prio(ext_prio), .onc_prio(onc_prio),
    .ext_wins(ext_wins)
  );

  park_owner_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rst_park(cfg_park_en), .int_mode(int_mode),
    .onc_req(onc_req), .onc_xfer_busy(onc_xfer_busy), .ext_br_n(ext_br_n),
    .ext_wins(ext_wins), .bus_bb_n(bus_bb_n), .arb_bg_n(arb_bg_n),
    .ext_bg_n(ext_bg_n), .own_bb_n(own_bb_n), .onc_grant(onc_grant),
    .onc_parked(onc_parked), .arb_br_n(arb_br_n)
  );
endmodule

// File: tb/tb_park_bus_arbiter.sv
module tb_park_bus_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_park_en = 1'b1;
  logic       prio_we = 1'b0;
  logic [2:0] prio_wdata = '0;
  logic       onc_req = 1'b0;
  logic [2:0] onc_prio = '0;
  logic       onc_xfer_busy = 1'b0;
  logic       ext_br_n = 1'b1;
  logic       ext_bb_n = 1'b1;
  logic       arb_bg_n = 1'b1;
  logic       bus_bb_n;
  logic       ext_bg_n, own_bb_n, onc_grant, onc_parked, arb_br_n;
  int         total = 0;
  int         bad = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  // shared busy line: wired-AND of both drivers
  assign bus_bb_n = own_bb_n & ext_bb_n;

  park_bus_arbiter dut (
    .clk(clk), .rst_n(rst_n), .cfg_park_en(cfg_park_en),
    .prio_we(prio_we), .prio_wdata(prio_wdata),
    .onc_req(onc_req), .onc_prio(onc_prio), .onc_xfer_busy(onc_xfer_busy),
    .ext_br_n(ext_br_n), .bus_bb_n(bus_bb_n), .arb_bg_n(arb_bg_n),
    .ext_bg_n(ext_bg_n), .own_bb_n(own_bb_n), .onc_grant(onc_grant),
    .onc_parked(onc_parked), .arb_br_n(arb_br_n)
  );

  // {req, prio[2:0], xfer, br_n, ext_bb_n, exp{parked,grant,bg_n,bb_n,arb_br_n}, req id}
  localparam int NV = 18;
  localparam logic [15:0] VEC [NV] = '{
    16'b0_000_0_1_1_10111_0010, // R2 idle, stays parked
    16'b1_010_1_1_1_01101_0011, // R3 take without grant cycle
    16'b1_010_1_0_1_01101_0110, // R6 higher ext waits for transfer
    16'b1_010_0_0_1_00011_0101, // R5 release to higher ext
    16'b1_010_0_0_1_00011_0111, // R7 grant held until ext busy
    16'b1_010_0_0_0_00111_0111, // R7 ext busy, grant dropped
    16'b1_010_0_1_0_00111_0111, // R7 on-chip waits during ext tenure
    16'b1_010_0_1_1_10111_0111, // R7 line free, parked again
    16'b1_010_1_1_1_01101_0011, // R3 take again
    16'b0_010_0_1_1_10111_0110, // R6 release to parking
    16'b0_000_0_0_1_00011_0100, // R4 no on-chip demand
    16'b0_000_0_1_1_10111_0111, // R7 request withdrawn
    16'b1_100_1_0_1_01101_0101, // R5 equal priority, on-chip takes
    16'b1_100_0_0_1_01101_0101, // R5 equal priority, on-chip keeps
    16'b1_011_0_0_1_00011_0101, // R5 lower on-chip priority yields
    16'b0_000_0_1_1_10111_0111, // R7 withdrawn
    16'b1_111_0_0_1_01101_0101, // R5 on-chip above ext
    16'b0_000_0_1_1_10111_0110  // R6 release
  };

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {parked,grant,bg_n,bb_n,arb_br_n} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {onc_parked, onc_grant, ext_bg_n, own_bb_n, arb_br_n};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0;
    cfg_park_en = strap;
    onc_req = 1'b0; onc_xfer_busy = 1'b0; ext_br_n = 1'b1; ext_bb_n = 1'b1;
    arb_bg_n = 1'b1; prio_we = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R2 reset state in internal mode
    do_reset(1'b1);
    check("R2 reset parked", outs(), 5'b10111);

    // vector table, internal mode, ext priority 4
    for (int i = 0; i < NV; i++) begin
      onc_req       = VEC[i][15];
      onc_prio      = VEC[i][14:12];
      onc_xfer_busy = VEC[i][11];
      ext_br_n      = VEC[i][10];
      ext_bb_n      = VEC[i][9];
      tick();
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i), outs(), VEC[i][8:4]);
    end

    // R8 write priority 6, on-chip at 5 loses from parking
    onc_req = 1'b0; ext_br_n = 1'b1; ext_bb_n = 1'b1;
    prio_we = 1'b1; prio_wdata = 3'd6;
    tick();
    prio_we = 1'b0;
    onc_req = 1'b1; onc_prio = 3'd5; ext_br_n = 1'b0;
    tick();
    check("R8 written priority wins", outs(), 5'b00011);
    onc_req = 1'b0; ext_br_n = 1'b1;
    tick();
    check("R8 back to parking", outs(), 5'b10111);

    // R8 reset restores 4: equal with on-chip 4 so on-chip takes
    do_reset(1'b1);
    onc_req = 1'b1; onc_prio = 3'd4; ext_br_n = 1'b0; onc_xfer_busy = 1'b0;
    tick();
    check("R8 reset priority value", outs(), 5'b01101);

    // R1/R9 outside-arbiter mode
    do_reset(1'b0);
    check("R9 reset not parked", outs(), 5'b00111);
    cfg_park_en = 1'b1; // strap change after reset must not matter (R1)
    onc_req = 1'b1; onc_prio = 3'd0; ext_br_n = 1'b0;
    tick();
    check("R9 request to outside arbiter", outs(), 5'b00110);
    tick();
    check("R9 waits for outside grant", outs(), 5'b00110);
    arb_bg_n = 1'b0; onc_xfer_busy = 1'b1;
    tick();
    check("R9 owns after outside grant", outs(), 5'b01101);
    onc_req = 1'b0; onc_xfer_busy = 1'b0; arb_bg_n = 1'b1;
    tick();
    check("R1 strap change ignored, idle unparked", outs(), 5'b00111);

    // R1 new reset picks up the strap again
    do_reset(1'b1);
    check("R1 strap resampled at reset", outs(), 5'b10111);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule